// File: doc/BRIEF.md
# Peripheral interrupt routing controller

This block gathers up to 64 level-sensitive peripheral interrupt requests and steers each one onto one of nine general-purpose request lines toward the core event controller. Those lines carry core levels 7 to 15. Every source has its own 4-bit routing ID, which software can program. The ID selects the output line, so line k carries core level k+7. Any number of sources may share one line, and their unmasked requests are ORed together. Per-source mask, status and wakeup-enable bits are held in two 32-bit banks. Bank 0 covers sources 0 to 31 and bank 1 covers sources 32 to 63.

Software reaches these registers through a plain synchronous port with a word address and a write strobe. A read returns the addressed value combinationally in the same cycle, and a write lands on the next rising clock edge. A separate wakeup output asks the power logic to revive the core when an enabled source asserts while the core is idle or asleep. A fixed set of source indices is reserved: 49, 50 and 56 to 63. Those sources never take effect.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset the following hold:
  - every mask and wakeup-enable bit is 0;
  - `lvl_irq` is all zero and `wake_out` is 0;
  - each assignment register n reads with all eight fields equal to n (register 0 reads 0x00000000, register 5 reads 0x55555555).
- R2: Status bank b (address 2+b) bit i reads 1 when source 32b+i was asserted at the previous clock edge, whatever its mask bit says.
- R3: A source whose mask bit is 0 never raises any `lvl_irq` bit.
- R4: Assignment register n is at address 8+n and holds sources 8n to 8n+7. The routing ID of source 8n+j is in bits 4j+3:4j.
- R5: `lvl_irq[k]` (core level k+7) is 1 two clock edges after an unmasked source with routing ID k asserts. After a mask or ID write it follows one edge later than that write.
- R6: When several unmasked active sources share one ID, the line is the OR of them. It stays 1 until the last of them drops.
- R7: Sources 49, 50 and 56 to 63 are reserved, which means:
  - their status, mask and wakeup-enable bits always read 0;
  - writing 1 to those mask or wakeup-enable bits has no effect;
  - their requests never reach `lvl_irq` or `wake_out`.
- R8: `wake_out` is 1 one edge after a cycle in which `core_idle` was 1 and some source with its wakeup-enable bit set showed status 1. This does not depend on the mask.
- R9: A routing ID of 9 or more sends the source to no output line.
- R10: The register addresses are as follows:
  - mask banks are at 0 and 1;
  - status banks are at 2 and 3 and are read-only, so writes to them are ignored;
  - wakeup-enable banks are at 4 and 5;
  - unmapped addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 64 | Level peripheral requests, one per source |
| core_idle | input | 1 | Core is idle or in sleep mode |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| lvl_irq | output | 9 | Request line per core level; bit k is level k+7 |
| wake_out | output | 1 | Wakeup request toward power control |

## Verification
The hardest situation to reach from the ports is a reserved source asserting while every other control bit is set. In that state the mask and wakeup-enable registers have been written all ones and the core is idle, so any leak of a reserved index would show at once. The stimulus reaches it by first writing all-ones words to bank 1 and reading them back. It then raises only reserved requests and checks that the status bits, `lvl_irq` and `wake_out` all stay 0. The routing checks move a single source between lines by rewriting one nibble of its assignment word. They also drop the sources of a merged line one at a time, to show that the OR holds until the last source is gone.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // word addresses of the register banks
  localparam int A_MASK_BASE = 0;
  localparam int A_STAT_BASE = 2;
  localparam int A_WAKE_BASE = 4;
  localparam int A_ASGN_BASE = 8;

  // reset routing ID of a source: the index of its assignment register
  function automatic int dflt_route(input int src, input int per_reg);
    return src / per_reg;
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture #(
  parameter int NUM_SRC = 64,
  parameter logic [NUM_SRC-1:0] RSVD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  output logic [NUM_SRC-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= irq_req & ~RSVD;
  end
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int BANK_W  = 32,
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] RSVD = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic                    reg_wr,
  input  logic [BANK_W-1:0]       reg_wdata,
  input  logic [NUM_SRC-1:0]      status_q,
  output logic [BANK_W-1:0]       reg_rdata,
  output logic [NUM_SRC-1:0]      mask_q,
  output logic [NUM_SRC-1:0]      wake_q,
  output logic [NUM_SRC*ID_W-1:0] id_q
);
  localparam int NB  = NUM_SRC / BANK_W;
  localparam int FPR = BANK_W / ID_W;
  localparam int NA  = NUM_SRC / FPR;

  function automatic logic [NUM_SRC*ID_W-1:0] dflt_ids();
    logic [NUM_SRC*ID_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_SRC; i++)
      r[i*ID_W +: ID_W] = ID_W'(dflt_route(i, FPR));
    return r;
  endfunction

  logic [31:0] a_int;
  assign a_int = 32'(reg_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      wake_q <= '0;
      id_q   <= dflt_ids();
    end else if (reg_wr) begin
      for (int b = 0; b < NB; b++) begin
        if (a_int == 32'(A_MASK_BASE + b))
          mask_q[b*BANK_W +: BANK_W] <= reg_wdata & ~RSVD[b*BANK_W +: BANK_W];
        if (a_int == 32'(A_WAKE_BASE + b))
          wake_q[b*BANK_W +: BANK_W] <= reg_wdata & ~RSVD[b*BANK_W +: BANK_W];
      end
      for (int a = 0; a < NA; a++)
        if (a_int == 32'(A_ASGN_BASE + a))
          id_q[a*BANK_W +: BANK_W] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (a_int == 32'(A_MASK_BASE + b)) reg_rdata = mask_q[b*BANK_W +: BANK_W];
      if (a_int == 32'(A_STAT_BASE + b)) reg_rdata = status_q[b*BANK_W +: BANK_W];
      if (a_int == 32'(A_WAKE_BASE + b)) reg_rdata = wake_q[b*BANK_W +: BANK_W];
    end
    for (int a = 0; a < NA; a++)
      if (a_int == 32'(A_ASGN_BASE + a)) reg_rdata = id_q[a*BANK_W +: BANK_W];
  end
endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 4,
  parameter int NUM_LVL = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_SRC-1:0]      status_q,
  input  logic [NUM_SRC-1:0]      mask_q,
  input  logic [NUM_SRC-1:0]      wake_q,
  input  logic [NUM_SRC*ID_W-1:0] id_q,
  input  logic                    core_idle,
  output logic [NUM_LVL-1:0]      lvl_irq,
  output logic                    wake_out
);
  logic [NUM_SRC-1:0] active;
  logic [NUM_LVL-1:0] lvl_next;
  logic               wake_next;

  assign active    = status_q & mask_q;
  assign wake_next = core_idle && ((status_q & wake_q) != '0);

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
        if (active[i] && (id_q[i*ID_W +: ID_W] == ID_W'(k))) hit = 1'b1;
    end
    assign lvl_next[k] = hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_irq  <= '0;
      wake_out <= 1'b0;
    end else begin
      lvl_irq  <= lvl_next;
      wake_out <= wake_next;
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NUM_SRC = 64,
  parameter int BANK_W  = 32,
  parameter int ID_W    = 4,
  parameter int NUM_LVL = 9,
  parameter int ADDR_W  = 4,
  parameter logic [NUM_SRC-1:0] RSVD = 64'hFF06_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic               core_idle,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [BANK_W-1:0]  reg_wdata,
  output logic [BANK_W-1:0]  reg_rdata,
  output logic [NUM_LVL-1:0] lvl_irq,
  output logic               wake_out
);
  logic [NUM_SRC-1:0]      status_q;
  logic [NUM_SRC-1:0]      mask_q;
  logic [NUM_SRC-1:0]      wake_q;
  logic [NUM_SRC*ID_W-1:0] id_q;

  irq_src_capture #(.NUM_SRC(NUM_SRC), .RSVD(RSVD)) u_cap (
    .clk(clk), .rst(rst), .irq_req(irq_req), .status_q(status_q)
  );

  irq_reg_file #(
    .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .ID_W(ID_W), .ADDR_W(ADDR_W), .RSVD(RSVD)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .status_q(status_q), .reg_rdata(reg_rdata),
    .mask_q(mask_q), .wake_q(wake_q), .id_q(id_q)
  );

  irq_level_merge #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .NUM_LVL(NUM_LVL)) u_merge (
    .clk(clk), .rst(rst), .status_q(status_q), .mask_q(mask_q),
    .wake_q(wake_q), .id_q(id_q), .core_idle(core_idle),
    .lvl_irq(lvl_irq), .wake_out(wake_out)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 64,
  parameter int NUM_LVL = 9,
  parameter logic [NUM_SRC-1:0] RSVD = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               core_idle,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] wake_q,
  input logic [NUM_LVL-1:0] lvl_irq,
  input logic               wake_out
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lvl_irq == '0 && !wake_out));

  // R2
  status_track_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_q == $past(irq_req & ~RSVD)));

  // R3
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_irq != '0) |-> $past((status_q & mask_q) != '0));

  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wake_out |-> $past(core_idle && ((status_q & wake_q) != '0)));
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .RSVD(RSVD)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .core_idle(core_idle),
  .status_q(status_q), .mask_q(mask_q), .wake_q(wake_q),
  .lvl_irq(lvl_irq), .wake_out(wake_out)
);

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_req = '0;
  logic        core_idle = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  lvl_irq;
  logic        wake_out;

  irq_router uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .core_idle(core_idle),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lvl_irq(lvl_irq), .wake_out(wake_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [8:0] lvl;
    logic       wake;
    string      tag;
  } exp_t;

  exp_t queue_q[$];
  event mon_ev;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  // monitor: pops expected output items and compares them with the ports
  initial begin
    forever begin
      exp_t e;
      @(mon_ev);
      #1;
      e = queue_q.pop_front();
      total++;
      if (lvl_irq !== e.lvl || wake_out !== e.wake) begin
        bad++;
        $display("FAIL %s: lvl=%h wake=%b expected lvl=%h wake=%b",
                 e.tag, lvl_irq, wake_out, e.lvl, e.wake);
      end
    end
  end

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_out(input logic [8:0] lvl, input logic wk, input string tag);
    exp_t e;
    e.lvl = lvl; e.wake = wk; e.tag = tag;
    queue_q.push_back(e);
    -> mon_ev;
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s: addr %0d read %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_chk(4'd0, 32'h0, "R1 mask0");
    rd_chk(4'd5, 32'h0, "R1 wake1");
    rd_chk(4'd8, 32'h0, "R1 asgn0");
    rd_chk(4'd13, 32'h5555_5555, "R1 asgn5");
    expect_out(9'h000, 1'b0, "R1 outputs");

    // R2 status follows a masked request; R3 masked source stays off
    irq_req[3] = 1'b1;
    settle();
    rd_chk(4'd2, 32'h0000_0008, "R2 status0");
    expect_out(9'h000, 1'b0, "R3 masked");

    // R5 unmask source 3 (default ID 0 -> bit 0)
    wr(4'd0, 32'h0000_0008);
    @(negedge clk);
    expect_out(9'h001, 1'b0, "R5 id0 route");

    // R4 move source 3 to ID 6 via bits 15:12 of assignment register 0
    wr(4'd8, 32'h0000_6000);
    @(negedge clk);
    expect_out(9'h040, 1'b0, "R4 remap");
    rd_chk(4'd8, 32'h0000_6000, "R4 asgn0 read");

    // R6 sources 40 and 47 merge on ID 5
    irq_req[3] = 1'b0;
    irq_req[40] = 1'b1;
    irq_req[47] = 1'b1;
    wr(4'd1, 32'h0000_8100);
    settle();
    rd_chk(4'd3, 32'h0000_8100, "R2 status1");
    expect_out(9'h020, 1'b0, "R6 both");
    irq_req[40] = 1'b0;
    settle();
    expect_out(9'h020, 1'b0, "R6 one left");
    irq_req[47] = 1'b0;
    settle();
    expect_out(9'h000, 1'b0, "R6 none");

    // R7 reserved sources with every control bit set
    irq_req[49] = 1'b1;
    irq_req[56] = 1'b1;
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    core_idle = 1'b1;
    settle();
    rd_chk(4'd1, 32'h00F9_FFFF, "R7 mask1");
    rd_chk(4'd5, 32'h00F9_FFFF, "R7 wake1");
    rd_chk(4'd3, 32'h0000_0000, "R7 status1");
    expect_out(9'h000, 1'b0, "R7 outputs");
    irq_req[49] = 1'b0;
    irq_req[56] = 1'b0;
    core_idle = 1'b0;
    wr(4'd5, 32'h0000_0000);

    // R8 wakeup from source 55 (default ID 6), gated by core_idle
    irq_req[55] = 1'b1;
    wr(4'd5, 32'h0080_0000);
    settle();
    expect_out(9'h040, 1'b0, "R8 not idle");
    core_idle = 1'b1;
    settle();
    expect_out(9'h040, 1'b1, "R8 idle");
    wr(4'd1, 32'h0000_0000);
    settle();
    expect_out(9'h000, 1'b1, "R8 mask independent");
    core_idle = 1'b0;

    // R4 bank 1: source 55 is field 7 (bits 31:28) of assignment register 6
    wr(4'd1, 32'h0080_0000);
    wr(4'd14, 32'h8666_6666);
    settle();
    expect_out(9'h100, 1'b0, "R4 bank1 id8");
    rd_chk(4'd14, 32'h8666_6666, "R4 asgn6 read");

    // R9 ID 15 routes nowhere
    wr(4'd14, 32'hF666_6666);
    settle();
    expect_out(9'h000, 1'b0, "R9 id15");

    // R10 status is read-only, unmapped reads zero
    wr(4'd3, 32'hFFFF_FFFF);
    rd_chk(4'd3, 32'h0080_0000, "R10 status1 write ignored");
    rd_chk(4'd6, 32'h0, "R10 addr6");
    rd_chk(4'd7, 32'h0, "R10 addr7");

    settle();
    finish_run();
  end
endmodule